// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block executes one instruction per clock from a 32-bit load-store instruction subset. Each cycle it presents the program counter on an instruction port and takes back the addressed word. It splits that word into register, immediate or jump fields and reads two operands from a 32-by-32-bit register file. It then computes a result or a memory address and writes the outcome back before the next edge. Data memory sits outside the block and is reached through an address, write-data, write-enable and combinational read-data port.

Three instruction layouts are decoded. Register-form words carry op 0 and select the operation by a function code in bits [5:0]. Immediate-form words carry a 16-bit two's-complement constant in bits [15:0] and write their result to the register named in bits [20:16]. Jump-form words carry a 26-bit word target in bits [25:0]. Control flow covers equal and not-equal branches, a direct jump, a direct call that leaves a return address in register 31, and an indirect jump through a register.

Top module: `rcore_top`

## Requirements
- R1: While the reset input is low, and for the two clock edges after it rises, the instruction address is 0 and the data write enable is 0. The first instruction executed is the one at byte address 0.
- R2: Every instruction other than a branch, jump, call or indirect jump moves the instruction address to the current address plus 4.
- R3: With op 0, funct 32 writes rs+rt, 34 writes rs-rt, 36 writes rs AND rt, 37 writes rs OR rt and 39 writes NOT(rs OR rt). Each result goes to the register in bits [15:11].
- R4: With op 0, funct 0 writes rt shifted left and funct 2 writes rt shifted right, by the amount in bits [10:6]. Vacated bits are zero in both cases.
- R5: With op 0, funct 42 writes 1 to rd if rs < rt as signed numbers, else 0. Op 10 writes the same flag to rt, comparing rs with the sign-extended immediate.
- R6: Op 8 writes rs plus the sign-extended bits [15:0] to rt.
- R7: Op 35 (load) and op 43 (store) use the byte address rs plus the sign-extended immediate. A load writes the read data to rt. A store drives rt as write data with the write enable high and writes no register. No other instruction raises the write enable.
- R8: Register 0 reads as 0, and any write aimed at it is discarded.
- R9: Op 4 branches when rs equals rt, and op 5 branches when they differ. The taken target is address+4 plus the sign-extended immediate times 4. A branch that is not taken continues at address+4.
- R10: Op 2 jumps, and op 3 calls, to bits [31:28] of address+4 joined with bits [25:0] and two zero bits. A call also writes address+4 to register 31.
- R11: With op 0 and funct 8, the next instruction address is the value of rs. No register is written.
- R12: An instruction whose destination is also one of its sources reads the old value, and the new value is visible to the next instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released internally on a clock edge |
| imem_addr | output | 32 | Byte address of the instruction being executed |
| imem_data | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Byte address for loads and stores |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, sampled by the memory on the rising edge |
| dmem_rdata | input | 32 | Load data for dmem_addr, combinational |

## Verification
The register file's read ports and its write port address the same entry in the same cycle whenever an instruction names its destination as a source. The loop counter decrement and the self-doubling add both do this, so the old operand must be read while the new value is written at the edge. The programs are arranged so that the stored results, the loop trip count and the final sum each differ if a read returned the value being written. A second overlap, a call whose target is an indirect jump through the link register, checks that the return address written on one edge is the one the jump reads in a later cycle.

// File: rtl/rcore_pkg.sv
package rcore_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'd0;
  localparam logic [5:0] OP_J     = 6'd2;
  localparam logic [5:0] OP_JAL   = 6'd3;
  localparam logic [5:0] OP_BEQ   = 6'd4;
  localparam logic [5:0] OP_BNE   = 6'd5;
  localparam logic [5:0] OP_ADDI  = 6'd8;
  localparam logic [5:0] OP_SLTI  = 6'd10;
  localparam logic [5:0] OP_LW    = 6'd35;
  localparam logic [5:0] OP_SW    = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_NOR = 6'd39;
  localparam logic [5:0] FN_SLT = 6'd42;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_NOR, ALU_SLT, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;
  typedef enum logic [1:0] {DST_RD, DST_RT, DST_RA} dst_sel_e;

  typedef struct packed {
    logic     rf_we;
    dst_sel_e dst;
    logic     use_imm;
    alu_op_e  alu_op;
    wb_sel_e  wb;
    logic     mem_we;
    logic     is_beq;
    logic     is_bne;
    logic     is_jmp;
    logic     is_jr;
  } ctl_t;
endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
  import rcore_pkg::*;
(
  input  logic [5:0] op,
  input  logic [5:0] funct,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    unique case (op)
      OP_RTYPE: begin
        ctl.dst   = DST_RD;
        ctl.rf_we = 1'b1;
        unique case (funct)
          FN_ADD:  ctl.alu_op = ALU_ADD;
          FN_SUB:  ctl.alu_op = ALU_SUB;
          FN_AND:  ctl.alu_op = ALU_AND;
          FN_OR:   ctl.alu_op = ALU_OR;
          FN_NOR:  ctl.alu_op = ALU_NOR;
          FN_SLT:  ctl.alu_op = ALU_SLT;
          FN_SLL:  ctl.alu_op = ALU_SLL;
          FN_SRL:  ctl.alu_op = ALU_SRL;
          FN_JR: begin
            ctl.rf_we = 1'b0;
            ctl.is_jr = 1'b1;
          end
          default: ctl.rf_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctl.rf_we   = 1'b1;
        ctl.dst     = DST_RT;
        ctl.use_imm = 1'b1;
      end
      OP_SLTI: begin
        ctl.rf_we   = 1'b1;
        ctl.dst     = DST_RT;
        ctl.use_imm = 1'b1;
        ctl.alu_op  = ALU_SLT;
      end
      OP_LW: begin
        ctl.rf_we   = 1'b1;
        ctl.dst     = DST_RT;
        ctl.use_imm = 1'b1;
        ctl.wb      = WB_MEM;
      end
      OP_SW: begin
        ctl.use_imm = 1'b1;
        ctl.mem_we  = 1'b1;
      end
      OP_BEQ: ctl.is_beq = 1'b1;
      OP_BNE: ctl.is_bne = 1'b1;
      OP_J:   ctl.is_jmp = 1'b1;
      OP_JAL: begin
        ctl.is_jmp = 1'b1;
        ctl.rf_we  = 1'b1;
        ctl.dst    = DST_RA;
        ctl.wb     = WB_LINK;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
  import rcore_pkg::*;
#(
  parameter int W  = XLEN,
  localparam int SW = $clog2(W)
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [SW-1:0]  shamt,
  output logic [W-1:0]   y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_NOR: y = ~(a | b);
      ALU_SLT: y = {{(W-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLL: y = b << shamt;
      ALU_SRL: y = b >> shamt;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/rcore_regfile.sv
module rcore_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);
  logic [W-1:0] regs [NREG];
  logic         wr_en;

  assign wr_en = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (wr_en) regs[waddr] <= wdata;
  end

  assign ra_data = (ra_addr == '0) ? '0 : regs[ra_addr];
  assign rb_data = (rb_addr == '0) ? '0 : regs[rb_addr];

  // R3 R12: an accepted write is held by the addressed entry after the edge
  p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/rcore_top.sv
module rcore_top
  import rcore_pkg::*;
#(
  parameter logic [31:0] RESET_PC = 32'h0000_0000,
  parameter int          NREG     = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata
);
  localparam int AW = $clog2(NREG);
  localparam logic [AW-1:0] LINK_REG = AW'(NREG - 1);

  // reset: asynchronous assertion, release on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // instruction fields
  logic [5:0]    f_op, f_fn;
  logic [AW-1:0] f_rs, f_rt, f_rd;
  logic [4:0]    f_sh;
  logic [31:0]   imm_sx;
  ctl_t          ctl;

  assign f_op   = imem_data[31:26];
  assign f_rs   = imem_data[25:21];
  assign f_rt   = imem_data[20:16];
  assign f_rd   = imem_data[15:11];
  assign f_sh   = imem_data[10:6];
  assign f_fn   = imem_data[5:0];
  assign imm_sx = {{16{imem_data[15]}}, imem_data[15:0]};

  rcore_decode u_dec (.op(f_op), .funct(f_fn), .ctl(ctl));

  // register file
  logic [31:0]   rs_val, rt_val, rf_wdata;
  logic [AW-1:0] rf_waddr;
  logic          rf_we;

  rcore_regfile #(.W(32), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_q_n),
    .ra_addr(f_rs), .ra_data(rs_val),
    .rb_addr(f_rt), .rb_data(rt_val),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata)
  );

  // execute
  logic [31:0] alu_y;

  rcore_alu #(.W(32)) u_alu (
    .op(ctl.alu_op), .a(rs_val), .b(ctl.use_imm ? imm_sx : rt_val),
    .shamt(f_sh), .y(alu_y)
  );

  // program counter: next-state and register
  logic [31:0] pc_q, pc_d, pc_plus4, br_tgt, jmp_tgt;
  logic        br_take;

  assign pc_plus4 = pc_q + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_sx[29:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], imem_data[25:0], 2'b00};
  assign br_take  = (ctl.is_beq && (rs_val == rt_val)) ||
                    (ctl.is_bne && (rs_val != rt_val));

  always_comb begin
    if (ctl.is_jr)       pc_d = rs_val;
    else if (ctl.is_jmp) pc_d = jmp_tgt;
    else if (br_take)    pc_d = br_tgt;
    else                 pc_d = pc_plus4;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) pc_q <= RESET_PC;
    else          pc_q <= pc_d;
  end

  // write-back
  always_comb begin
    unique case (ctl.dst)
      DST_RT:  rf_waddr = f_rt;
      DST_RA:  rf_waddr = LINK_REG;
      default: rf_waddr = f_rd;
    endcase
    unique case (ctl.wb)
      WB_MEM:  rf_wdata = dmem_rdata;
      WB_LINK: rf_wdata = pc_plus4;
      default: rf_wdata = alu_y;
    endcase
  end

  assign rf_we      = ctl.rf_we && rst_q_n;
  assign imem_addr  = pc_q;
  assign dmem_addr  = alu_y;
  assign dmem_wdata = rt_val;
  assign dmem_we    = ctl.mem_we && rst_q_n;

  // assertions
  p_seq_pc_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ctl.is_jmp && !ctl.is_jr && !ctl.is_beq && !ctl.is_bne)
      |=> (imem_addr == $past(imem_addr) + 32'd4));

  p_slt_flag_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl.alu_op == ALU_SLT) |-> (alu_y[31:1] == 31'd0));

  p_srl_fill_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl.alu_op == ALU_SRL && !ctl.use_imm)
      |-> ((alu_y & ~(32'hFFFF_FFFF >> f_sh)) == 32'd0));

  p_store_no_wb_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    dmem_we |-> !rf_we);

  p_beq_taken_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl.is_beq && rs_val == rt_val) |=> (imem_addr == $past(br_tgt)));

  p_link_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctl.wb == WB_LINK) |-> (rf_we && rf_waddr == LINK_REG &&
                             rf_wdata == imem_addr + 32'd4));
endmodule

// File: tb/rcore_top_test.sv
module rcore_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  int n_chk = 0, n_bad = 0, n_wr = 0, cyc = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  rcore_top uut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
  always @(negedge clk) if (dmem_we) n_wr++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, actual %0d cycles expected < 20000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] enc_i(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] enc_j(int op, int byte_tgt);
    return {6'(op), 26'(byte_tgt >> 2)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'd0;
      dmem[i] = 32'd0;
    end
  endtask

  task automatic run_prog(input int cycles);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    n_wr = 0;
    rst_n = 1'b1;
    repeat (cycles) @(negedge clk);
  endtask

  // R1 R2: reset state, store gating during reset, sequential advance
  task automatic t_reset();
    clear_mem();
    imem[0] = enc_i(43, 0, 0, 32);
    imem[1] = enc_i(8, 0, 1, 1);
    imem[2] = enc_i(8, 0, 2, 2);
    imem[3] = enc_i(8, 0, 3, 3);
    imem[4] = enc_j(2, 16);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 pc in reset", imem_addr, 32'd0);
    chk("R1 we in reset", {31'd0, dmem_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc during release", imem_addr, 32'd0);
    chk("R1 we during release", {31'd0, dmem_we}, 32'd0);
    @(negedge clk);
    chk("R1 first fetch at 0", imem_addr, 32'd0);
    chk("R1 first instr is store", {31'd0, dmem_we}, 32'd1);
    @(negedge clk);
    chk("R2 pc+4", imem_addr, 32'd4);
    @(negedge clk);
    chk("R2 pc+8", imem_addr, 32'd8);
  endtask

  // R3 R6 R8 R12: register arithmetic, immediates, register 0, self-reference
  task automatic t_arith();
    clear_mem();
    imem[0]  = enc_i(8, 0, 17, 100);
    imem[1]  = enc_i(8, 0, 18, -30);
    imem[2]  = enc_i(8, 0, 19, 5);
    imem[3]  = 32'h0232_8020;
    imem[4]  = 32'h2268_FFF4;
    imem[5]  = enc_r(17, 18, 9, 0, 34);
    imem[6]  = enc_r(17, 18, 10, 0, 36);
    imem[7]  = enc_r(17, 18, 11, 0, 37);
    imem[8]  = enc_r(17, 18, 12, 0, 39);
    imem[9]  = enc_i(8, 0, 0, 77);
    imem[10] = enc_i(8, 0, 14, 3);
    imem[11] = enc_r(14, 14, 14, 0, 32);
    imem[12] = enc_r(14, 17, 14, 0, 34);
    imem[13] = enc_i(43, 0, 16, 0);
    imem[14] = enc_i(43, 0, 8, 4);
    imem[15] = enc_i(43, 0, 9, 8);
    imem[16] = enc_i(43, 0, 10, 12);
    imem[17] = enc_i(43, 0, 11, 16);
    imem[18] = enc_i(43, 0, 12, 20);
    imem[19] = enc_i(43, 0, 0, 24);
    imem[20] = enc_i(43, 0, 14, 28);
    imem[21] = enc_j(2, 84);
    run_prog(40);
    chk("R3 add 0x02328020", dmem[0], 32'd70);
    chk("R6 addi 0x2268FFF4", dmem[1], 32'hFFFF_FFF9);
    chk("R3 sub", dmem[2], 32'd130);
    chk("R3 and", dmem[3], 32'h0000_0060);
    chk("R3 or", dmem[4], 32'hFFFF_FFE6);
    chk("R3 nor", dmem[5], 32'h0000_0019);
    chk("R8 write to r0 ignored", dmem[6], 32'd0);
    chk("R12 self-referencing dest", dmem[7], 32'hFFFF_FFA2);
    chk("R7 store count", 32'(n_wr), 32'd8);
  endtask

  // R4 R5: shifts with zero fill, signed compares
  task automatic t_shift_slt();
    clear_mem();
    imem[0]  = enc_i(8, 0, 1, -1);
    imem[1]  = enc_r(0, 1, 2, 4, 0);
    imem[2]  = enc_r(0, 1, 3, 28, 2);
    imem[3]  = enc_r(0, 1, 4, 0, 2);
    imem[4]  = enc_r(1, 0, 5, 0, 42);
    imem[5]  = enc_r(0, 1, 6, 0, 42);
    imem[6]  = enc_i(10, 1, 7, -2);
    imem[7]  = enc_i(10, 1, 8, 0);
    imem[8]  = enc_r(0, 1, 9, 31, 0);
    for (int k = 0; k < 8; k++) imem[9+k] = enc_i(43, 0, 2+k, 4*k);
    imem[17] = enc_j(2, 68);
    run_prog(30);
    chk("R4 sll 4", dmem[0], 32'hFFFF_FFF0);
    chk("R4 srl 28", dmem[1], 32'h0000_000F);
    chk("R4 srl 0", dmem[2], 32'hFFFF_FFFF);
    chk("R5 slt -1<0", dmem[3], 32'd1);
    chk("R5 slt 0<-1", dmem[4], 32'd0);
    chk("R5 slti -1<-2", dmem[5], 32'd0);
    chk("R5 slti -1<0", dmem[6], 32'd1);
    chk("R4 sll 31", dmem[7], 32'h8000_0000);
  endtask

  // R9 R12: backward bne loop, untaken and taken beq
  task automatic t_branch();
    clear_mem();
    imem[0]  = enc_i(8, 0, 1, 0);
    imem[1]  = enc_i(8, 0, 2, 5);
    imem[2]  = enc_r(1, 2, 1, 0, 32);
    imem[3]  = enc_i(8, 2, 2, -1);
    imem[4]  = enc_i(5, 2, 0, -3);
    imem[5]  = enc_i(4, 1, 0, 1);
    imem[6]  = enc_i(8, 0, 3, 7);
    imem[7]  = enc_i(4, 0, 0, 1);
    imem[8]  = enc_i(8, 0, 3, 99);
    imem[9]  = enc_i(43, 0, 1, 0);
    imem[10] = enc_i(43, 0, 3, 4);
    imem[11] = enc_i(43, 0, 2, 8);
    imem[12] = enc_j(2, 48);
    run_prog(50);
    chk("R9 bne loop sum", dmem[0], 32'd15);
    chk("R9 beq untaken then taken", dmem[1], 32'd7);
    chk("R12 counter decrement", dmem[2], 32'd0);
  endtask

  // R7 R10 R11: load, store with offset, call, return, jump
  task automatic t_mem_jump();
    clear_mem();
    dmem[16] = 32'hCAFE_F00D;
    imem[0]  = enc_i(8, 0, 6, 0);
    imem[1]  = enc_i(8, 0, 4, 32'h50);
    imem[2]  = enc_i(35, 4, 5, -16);
    imem[3]  = enc_i(43, 4, 5, -12);
    imem[4]  = enc_j(3, 32'h24);
    imem[5]  = enc_i(43, 0, 31, 8);
    imem[6]  = enc_j(2, 32'h34);
    imem[7]  = enc_i(8, 0, 6, 1);
    imem[8]  = enc_i(8, 0, 6, 3);
    imem[9]  = enc_i(8, 0, 7, 42);
    imem[10] = enc_r(31, 0, 0, 0, 8);
    imem[11] = enc_i(8, 0, 6, 2);
    imem[12] = enc_i(8, 0, 6, 4);
    imem[13] = enc_i(43, 0, 7, 12);
    imem[14] = enc_i(43, 0, 6, 16);
    imem[15] = enc_j(2, 32'h3C);
    run_prog(40);
    chk("R7 load source untouched", dmem[16], 32'hCAFE_F00D);
    chk("R7 load then store offset", dmem[17], 32'hCAFE_F00D);
    chk("R10 link value", dmem[2], 32'h0000_0014);
    chk("R11 return path ran callee", dmem[3], 32'd42);
    chk("R10 R11 skipped words", dmem[4], 32'd0);
    chk("R7 store count", 32'(n_wr), 32'd4);
  endtask

  initial begin
    t_reset();
    t_arith();
    t_shift_slt();
    t_branch();
    t_mem_jump();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule